// File: doc/BRIEF.md
# Row-Stationary Convolution Grid

This block is a square grid of row-convolution elements that computes a small 2D convolution in one pass. With the default grid of three, a three-row filter slides over a five-row input map and yields three output rows. Each element holds one filter row and one input row in local registers. It produces the 1D convolution of the two rows and adds that to the partial sum coming up from the element below it.

Filter rows are shared across the elements of an array row. Each input row is shared along an anti-diagonal of the grid. Partial sums travel directly upward from element to element inside a column, with no trip through an outside buffer. The top element of each column therefore holds one finished output row.

Rows are loaded while the grid is idle. A start pulse launches the accumulation wave from the bottom row. The finished rows then leave through a single output stream, one row per cycle in column order, and a done pulse follows.

Top module: `rs_pe_array`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and they stay low until a run is started.
- R2: A filter load with row index `flt_row` = i writes `flt_data` into every element of array row i. Tap s of the filter row sits at bits [s*DATA_W +: DATA_W].
- R3: An input load with row index `in_row` = k writes `in_data` into every element at array row i and column j with i+j = k. Sample n sits at bits [n*DATA_W +: DATA_W].
- R4: The output row with index j is the convolution of the whole filter with input rows j to j+GRID-1. Element e, at bits [e*ACC_W +: ACC_W], equals the sum over r and s of filter(r,s) times input(r+j, e+s). It is computed in two's complement, signed when SIGNED = 1, and truncated to ACC_W bits.
- R5: Partial sums move up one array row per cycle, starting at the bottom row. The first output row appears GRID+1 cycles after the clock edge that samples `start`.
- R6: The output rows leave on GRID consecutive cycles with `out_row` counting 0, 1, ..., GRID-1. Exactly GRID rows are emitted per run.
- R7: `done` is high for exactly one cycle, in the cycle right after the last output row.
- R8: Filter and input loads are ignored while a run is in progress. Neither the rows of that run nor the rows of later runs change.
- R9: A `start` pulse during a run is ignored. It causes no extra output rows.
- R10: The loaded rows stay in place after a run, so a second start without reloading gives identical output rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_we | input | 1 | Filter row write strobe |
| flt_row | input | $clog2(GRID) | Filter row index (array row) |
| flt_data | input | FILT_LEN*DATA_W | Packed filter taps |
| in_we | input | 1 | Input row write strobe |
| in_row | input | $clog2(2*GRID-1) | Input map row index (anti-diagonal) |
| in_data | input | IN_LEN*DATA_W | Packed input samples |
| start | input | 1 | Launch a convolution pass |
| out_valid | output | 1 | Output row present |
| out_row | output | $clog2(GRID) | Index of the output row |
| out_data | output | (IN_LEN-FILT_LEN+1)*ACC_W | Packed output row |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
On every cycle, the bound checker watches the timing skeleton. It checks the fixed GRID+1 latency from an accepted start to the first row, the strict 0..GRID-1 ordering of emitted rows, that the first row carries index zero, and that `done` is a single cycle directly after the last row. The actual arithmetic can only be shown by the bench scenarios. These compare every emitted row against a 2D convolution computed in the bench, and they cover the routing of filter rows, diagonal input rows and upward partial sums. The same holds for the ignored loads and the ignored restart during a run, and for a rerun on the kept rows. Signed extremes such as -128 times 127 are included.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_RUN  = 2'd1,
      RS_EMIT = 2'd2
   } rs_state_e;
endpackage

// File: rtl/rs_row_pe.sv
module rs_row_pe #(
   parameter int DATA_W   = 8,
   parameter int ACC_W    = 20,
   parameter int FILT_LEN = 3,
   parameter int IN_LEN   = 7,
   parameter bit SIGNED   = 1'b1,
   localparam int OUT_LEN = IN_LEN - FILT_LEN + 1,
   localparam int OUT_W   = OUT_LEN * ACC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flt_we,
   input  logic [FILT_LEN*DATA_W-1:0] flt_d,
   input  logic                       in_we,
   input  logic [IN_LEN*DATA_W-1:0]   in_d,
   input  logic [OUT_W-1:0]           ps_in,
   input  logic                       ps_in_vld,
   output logic [OUT_W-1:0]           ps_out,
   output logic                       ps_out_vld
);
   logic [FILT_LEN*DATA_W-1:0] w_q;
   logic [IN_LEN*DATA_W-1:0]   x_q;
   logic [OUT_W-1:0]           nxt_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q <= '0;
         x_q <= '0;
      end else begin
         if (flt_we) w_q <= flt_d;
         if (in_we)  x_q <= in_d;
      end
   end

   for (genvar e = 0; e < OUT_LEN; e++) begin : g_tap
      logic [ACC_W-1:0] dot;
      if (SIGNED) begin : g_sgn
         always_comb begin
            dot = '0;
            for (int s = 0; s < FILT_LEN; s++) begin
               dot = dot + ACC_W'($signed(w_q[s*DATA_W +: DATA_W]))
                         * ACC_W'($signed(x_q[(e+s)*DATA_W +: DATA_W]));
            end
         end
      end else begin : g_uns
         always_comb begin
            dot = '0;
            for (int s = 0; s < FILT_LEN; s++) begin
               dot = dot + ACC_W'(w_q[s*DATA_W +: DATA_W])
                         * ACC_W'(x_q[(e+s)*DATA_W +: DATA_W]);
            end
         end
      end
      assign nxt_v[e*ACC_W +: ACC_W] = ps_in[e*ACC_W +: ACC_W] + dot;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_out     <= '0;
         ps_out_vld <= 1'b0;
      end else begin
         ps_out_vld <= ps_in_vld;
         if (ps_in_vld) ps_out <= nxt_v;
      end
   end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
   import rs_pkg::*;
#(
   parameter int GRID = 3,
   localparam int IDX_W = $clog2(GRID)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             top_vld,
   output logic             idle,
   output logic             kick,
   output logic             emit,
   output logic [IDX_W-1:0] emit_idx,
   output logic             done
);
   rs_state_e state_q;

   assign idle = (state_q == RS_IDLE);
   assign kick = start && idle;
   assign emit = (state_q == RS_EMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= RS_IDLE;
         emit_idx <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            RS_IDLE: if (start) state_q <= RS_RUN;
            RS_RUN: if (top_vld) begin
               state_q  <= RS_EMIT;
               emit_idx <= '0;
            end
            RS_EMIT: begin
               if (emit_idx == IDX_W'(GRID - 1)) begin
                  state_q <= RS_IDLE;
                  done    <= 1'b1;
               end else begin
                  emit_idx <= emit_idx + 1'b1;
               end
            end
            default: state_q <= RS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rs_pe_array.sv
module rs_pe_array #(
   parameter int GRID     = 3,
   parameter int FILT_LEN = 3,
   parameter int IN_LEN   = 7,
   parameter int DATA_W   = 8,
   parameter int ACC_W    = 20,
   parameter bit SIGNED   = 1'b1,
   localparam int OUT_LEN = IN_LEN - FILT_LEN + 1,
   localparam int OUT_W   = OUT_LEN * ACC_W,
   localparam int FR_W    = $clog2(GRID),
   localparam int IR_W    = $clog2(2*GRID - 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flt_we,
   input  logic [FR_W-1:0]            flt_row,
   input  logic [FILT_LEN*DATA_W-1:0] flt_data,
   input  logic                       in_we,
   input  logic [IR_W-1:0]            in_row,
   input  logic [IN_LEN*DATA_W-1:0]   in_data,
   input  logic                       start,
   output logic                       out_valid,
   output logic [FR_W-1:0]            out_row,
   output logic [OUT_W-1:0]           out_data,
   output logic                       done
);
   if (GRID < 2) begin : g_bad_grid
      $error("rs_pe_array: GRID must be at least 2");
   end
   if (IN_LEN < FILT_LEN) begin : g_bad_len
      $error("rs_pe_array: IN_LEN must not be below FILT_LEN");
   end
   if (ACC_W < 2*DATA_W + $clog2(FILT_LEN*GRID)) begin : g_bad_acc
      $error("rs_pe_array: ACC_W too narrow for the full sum");
   end

   logic             idle_w, kick_w, emit_w, top_vld;
   logic [FR_W-1:0]  emit_idx;
   logic [OUT_W-1:0] ps_lv  [GRID+1][GRID];
   logic             vld_lv [GRID+1][GRID];

   for (genvar j = 0; j < GRID; j++) begin : g_base
      assign ps_lv[GRID][j]  = '0;
      assign vld_lv[GRID][j] = kick_w;
   end

   for (genvar i = 0; i < GRID; i++) begin : g_row
      for (genvar j = 0; j < GRID; j++) begin : g_col
         logic f_we, x_we;
         assign f_we = flt_we && idle_w && (flt_row == FR_W'(i));
         assign x_we = in_we && idle_w && (in_row == IR_W'(i + j));
         rs_row_pe #(
            .DATA_W(DATA_W), .ACC_W(ACC_W), .FILT_LEN(FILT_LEN),
            .IN_LEN(IN_LEN), .SIGNED(SIGNED)
         ) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .flt_we    (f_we),
            .flt_d     (flt_data),
            .in_we     (x_we),
            .in_d      (in_data),
            .ps_in     (ps_lv[i+1][j]),
            .ps_in_vld (vld_lv[i+1][j]),
            .ps_out    (ps_lv[i][j]),
            .ps_out_vld(vld_lv[i][j])
         );
      end
   end

   always_comb begin
      top_vld = 1'b1;
      for (int j = 0; j < GRID; j++) top_vld = top_vld & vld_lv[0][j];
   end

   rs_ctrl #(.GRID(GRID)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .top_vld (top_vld),
      .idle    (idle_w),
      .kick    (kick_w),
      .emit    (emit_w),
      .emit_idx(emit_idx),
      .done    (done)
   );

   always_comb begin
      out_data = '0;
      for (int j = 0; j < GRID; j++) begin
         if (emit_idx == FR_W'(j)) out_data = ps_lv[0][j];
      end
   end

   assign out_valid = emit_w;
   assign out_row   = emit_idx;
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
   parameter int GRID = 3,
   localparam int FR_W = $clog2(GRID)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            idle,
   input logic            out_valid,
   input logic [FR_W-1:0] out_row,
   input logic            done
);
   logic [7:0] lat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                        lat_cnt <= '0;
      else if (start && idle)            lat_cnt <= 8'd1;
      else if (out_valid)                lat_cnt <= '0;
      else if (lat_cnt != '0)            lat_cnt <= lat_cnt + 8'd1;
   end

   assert_first_out_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (lat_cnt == 8'(GRID + 1)));

   assert_first_row_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_row == '0));

   assert_row_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_row != FR_W'(GRID - 1)) |=>
         (out_valid && out_row == $past(out_row) + 1'b1));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(out_valid) && $past(out_row) == FR_W'(GRID - 1)));
endmodule

bind rs_pe_array rs_array_chk #(.GRID(GRID)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .idle     (idle_w),
   .out_valid(out_valid),
   .out_row  (out_row),
   .done     (done)
);

// File: tb/tb_rs_pe_array.sv
`timescale 1ns/1ps
module tb_rs_pe_array;
   localparam int G   = 3;
   localparam int FL  = 3;
   localparam int IL  = 7;
   localparam int DW  = 8;
   localparam int AW  = 20;
   localparam int OL  = IL - FL + 1;
   localparam int OW  = OL * AW;
   localparam int NIR = 2*G - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               flt_we = 1'b0;
   logic [1:0]         flt_row = '0;
   logic [FL*DW-1:0]   flt_data = '0;
   logic               in_we = 1'b0;
   logic [2:0]         in_row = '0;
   logic [IL*DW-1:0]   in_data = '0;
   logic               start = 1'b0;
   logic               out_valid;
   logic [1:0]         out_row;
   logic [OW-1:0]      out_data;
   logic               done;

   int n_tests = 0;
   int n_fail  = 0;
   int wm [G][FL];
   int xm [NIR][IL];
   logic [OW-1:0] exp_q [$];
   int            exp_row_q [$];

   always #5 clk = ~clk;

   rs_pe_array dut (
      .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_row(flt_row),
      .flt_data(flt_data), .in_we(in_we), .in_row(in_row), .in_data(in_data),
      .start(start), .out_valid(out_valid), .out_row(out_row),
      .out_data(out_data), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // scoreboard monitor: R4 data and R6 index per emitted row
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected output row", out_row, -1);
         end else begin
            logic [OW-1:0] ev;
            int            er;
            ev = exp_q.pop_front();
            er = exp_row_q.pop_front();
            check(int'(out_row) == er, "R6", "row index", out_row, er);
            for (int e = 0; e < OL; e++) begin
               check(out_data[e*AW +: AW] == ev[e*AW +: AW], "R4", "row element",
                     $signed(out_data[e*AW +: AW]), $signed(ev[e*AW +: AW]));
            end
         end
      end
   end

   task automatic load_all();
      for (int r = 0; r < G; r++) begin
         @(negedge clk);
         flt_we = 1'b1; flt_row = 2'(r);
         for (int s = 0; s < FL; s++) flt_data[s*DW +: DW] = DW'(wm[r][s]);
      end
      for (int k = 0; k < NIR; k++) begin
         @(negedge clk);
         flt_we = 1'b0;
         in_we = 1'b1; in_row = 3'(k);
         for (int n = 0; n < IL; n++) in_data[n*DW +: DW] = DW'(xm[k][n]);
      end
      @(negedge clk);
      flt_we = 1'b0; in_we = 1'b0;
   endtask

   // R2/R3/R4 reference: row j uses filter row r with input row r+j
   task automatic push_expected();
      for (int j = 0; j < G; j++) begin
         logic [OW-1:0] v;
         for (int e = 0; e < OL; e++) begin
            int acc = 0;
            for (int r = 0; r < G; r++)
               for (int s = 0; s < FL; s++) acc += wm[r][s] * xm[r+j][e+s];
            v[e*AW +: AW] = AW'(acc);
         end
         exp_q.push_back(v);
         exp_row_q.push_back(j);
      end
   endtask

   task automatic run(input bit disturb, input bit restart);
      int first_out = 0, done_at = 0, done_cnt = 0, out_cnt = 0;
      push_expected();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 1; c <= 20; c++) begin
         if (c == 1 && disturb) begin
            flt_we = 1'b1; flt_row = 2'd0; flt_data = '1;
            in_we = 1'b1; in_row = 3'd2; in_data = {IL{8'h55}};
         end
         if (c == 2 && restart) start = 1'b1;
         if (out_valid) begin
            out_cnt++;
            if (first_out == 0) first_out = c;
         end
         if (done) begin
            done_cnt++;
            if (done_at == 0) done_at = c;
         end
         @(negedge clk);
         flt_we = 1'b0; in_we = 1'b0; start = 1'b0;
      end
      check(first_out == G + 1, "R5", "first row latency", first_out, G + 1);
      check(done_at == 2*G + 1, "R7", "done cycle", done_at, 2*G + 1);
      check(done_cnt == 1, "R7", "done width", done_cnt, 1);
      check(out_cnt == G, "R9", "rows per run", out_cnt, G);
      check(exp_q.size() == 0, "R6", "rows left unseen", exp_q.size(), 0);
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(done == 1'b0, "R1", "done after reset", done, 0);

      // ramp data: R2, R3, R4
      for (int r = 0; r < G; r++) for (int s = 0; s < FL; s++) wm[r][s] = r*3 + s + 1;
      for (int k = 0; k < NIR; k++) for (int n = 0; n < IL; n++) xm[k][n] = k*7 + n - 10;
      load_all();
      run(1'b0, 1'b0);

      // signed extremes: R4
      for (int r = 0; r < G; r++) for (int s = 0; s < FL; s++) wm[r][s] = -128;
      for (int k = 0; k < NIR; k++) for (int n = 0; n < IL; n++) xm[k][n] = 127;
      load_all();
      run(1'b0, 1'b0);

      // routing probe: only middle filter row tap 0 set, mixed-sign input (R2, R3)
      for (int r = 0; r < G; r++) for (int s = 0; s < FL; s++) wm[r][s] = (r == 1 && s == 0) ? 1 : 0;
      for (int k = 0; k < NIR; k++) for (int n = 0; n < IL; n++) xm[k][n] = ((k*31 + n*17) % 200) - 100;
      load_all();
      run(1'b0, 1'b0);

      // pseudo-random rows
      for (int r = 0; r < G; r++) for (int s = 0; s < FL; s++) wm[r][s] = ((r*53 + s*29 + 7) % 256) - 128;
      for (int k = 0; k < NIR; k++) for (int n = 0; n < IL; n++) xm[k][n] = ((k*97 + n*41 + 3) % 256) - 128;
      load_all();
      run(1'b0, 1'b0);

      // R8 loads ignored and R9 restart ignored during a run
      run(1'b1, 1'b1);
      // R10 kept rows: rerun with no reload, R8 dropped writes stay absent
      run(1'b0, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule